// File: doc/BRIEF.md
# Programmable FIFO Word Packing Unit

This unit sits between a 32-bit-wide data FIFO and a serial shift engine. On the transmit side it takes one 32-bit FIFO entry and breaks it into serial protocol words. On the receive side it gathers serial words and rebuilds 32-bit FIFO entries. Which bits of an entry make up each word, and in which order, is not fixed. It is set by a short table of packing vectors. Each vector names a starting bit, a walking direction, a chunk length of one to eight bits, and an end-of-sequence flag.

Transmit and receive each have their own pair of 32-bit configuration words, and each pair holds four vectors. A shared two-bit granularity code sets the width of a serial word: 8, 16 or 32 bits. Both sides use valid/ready handshakes. The unit processes one vector per clock cycle and holds its output steady while the downstream side is not ready.

Top module: `pack_word_unit`

## Requirements
- R1: Each 32-bit config word holds two vectors: bits 9:0 hold the lower-numbered vector and bits 19:10 the next one. The low config word holds vectors 0 and 1, and the high config word holds vectors 2 and 3. Within a vector, bits 9:5 are the start index, bit 4 is the direction, bits 3:1 are the chunk length minus one, and bit 0 is the stop flag.
- R2: On transmit, a vector reads length bits from the entry. It starts at the start index and moves downward when direction is 1 and upward when direction is 0. Indices wrap modulo 32. The first bit read becomes the most significant bit of the chunk.
- R3: On transmit, chunks are joined into a word with earlier chunks more significant. A word is emitted when at least the word width of bits has been gathered. Only its low word-width bits are kept, right-justified, and all higher bits are zero.
- R4: Granularity code 0 gives 8-bit words, 1 gives 16-bit words and 2 gives 32-bit words. Code 3 behaves exactly like code 0.
- R5: An entry's sequence ends after the first vector whose stop flag is 1, or after vector 3 if no stop flag is set. On transmit, any partly gathered word is emitted at that point, and no further word comes from that entry.
- R6: On receive, each vector takes length bits from the current word, most significant remaining bit first. Each bit is written to the entry position given by the same index walk as R2. A new word is accepted whenever a vector starts with no bits left. If fewer bits remain than the length, the missing trailing bits are zero. Entry bits that no vector writes are zero.
- R7: On receive, bits of the current word that are still unused when the sequence ends are discarded. The next entry starts from a fresh word.
- R8: The transmit config words affect only transmit, and the receive config words affect only receive.
- R9: While an output is valid and not accepted, it stays valid with unchanged data. No entry or word is lost or duplicated under back-pressure on either side.
- R10: After reset, both output valids are low and both input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_cfg_lo | input | 32 | Transmit vectors 0 and 1 |
| tx_cfg_hi | input | 32 | Transmit vectors 2 and 3 |
| rx_cfg_lo | input | 32 | Receive vectors 0 and 1 |
| rx_cfg_hi | input | 32 | Receive vectors 2 and 3 |
| gran_code | input | 2 | Serial word width code |
| tx_ent_valid | input | 1 | Transmit FIFO entry valid |
| tx_ent_ready | output | 1 | Transmit FIFO entry accepted |
| tx_ent_data | input | 32 | Transmit FIFO entry |
| tx_wrd_valid | output | 1 | Serial word to send is valid |
| tx_wrd_ready | input | 1 | Shift engine takes the word |
| tx_wrd_data | output | 32 | Serial word, right-justified |
| rx_wrd_valid | input | 1 | Received serial word valid |
| rx_wrd_ready | output | 1 | Received word accepted |
| rx_wrd_data | input | 32 | Received serial word, right-justified |
| rx_ent_valid | output | 1 | Rebuilt FIFO entry valid |
| rx_ent_ready | input | 1 | FIFO takes the entry |
| rx_ent_data | output | 32 | Rebuilt FIFO entry |

## Verification
The ordinary byte layouts are tried first, at all three widths and with the undefined code. These separate correct lane ordering and chunk concatenation from swapped or misaligned lanes. Single-vector cases then cover an early stop, an ascending walk and a walk that wraps past bit 0, which expose errors in direction, bit reversal and index wrap. On receive, a one-chunk 16-bit sequence shows whether leftover bits are discarded or wrongly carried into the next entry. Fully random vector tables, entries and words, under random back-pressure, are compared with a bit-serial reference model that walks one bit at a time.

// File: rtl/pack_pkg.sv
package pack_pkg;

    localparam int ENTRY_W   = 32;
    localparam int VEC_W     = 10;
    localparam int CHUNK_MAX = 8;
    localparam int CNT_W     = 6;

    typedef struct packed {
        logic [4:0] start;
        logic       desc;
        logic [2:0] len_m1;
        logic       stop;
    } vec_t;

    // serial word width selected by the granularity code
    function automatic logic [CNT_W-1:0] gran_width(input logic [1:0] code);
        case (code)
            2'd1:    return CNT_W'(16);
            2'd2:    return CNT_W'(32);
            default: return CNT_W'(8);
        endcase
    endfunction

    function automatic logic [ENTRY_W-1:0] width_mask(input logic [CNT_W-1:0] w);
        if (w >= CNT_W'(ENTRY_W))
            return '1;
        return (ENTRY_W'(1) << w) - ENTRY_W'(1);
    endfunction

    function automatic logic [3:0] chunk_len(input vec_t v);
        return {1'b0, v.len_m1} + 4'd1;
    endfunction

    function automatic logic [CHUNK_MAX-1:0] chunk_mask(input logic [3:0] len);
        return CHUNK_MAX'((16'd1 << len) - 16'd1);
    endfunction

    function automatic logic [4:0] walk_index(input vec_t v, input int k);
        return v.desc ? (v.start - 5'(k)) : (v.start + 5'(k));
    endfunction

    // read a chunk out of an entry; first bit read lands at the chunk MSB
    function automatic logic [CHUNK_MAX-1:0] pull_chunk(input logic [ENTRY_W-1:0] ent,
                                                        input vec_t v);
        logic [CHUNK_MAX-1:0] c;
        c = '0;
        for (int k = 0; k < CHUNK_MAX; k++) begin
            if (3'(k) <= v.len_m1)
                c = {c[CHUNK_MAX-2:0], ent[walk_index(v, k)]};
        end
        return c;
    endfunction

    // write a chunk back into an entry along the same walk
    function automatic logic [ENTRY_W-1:0] push_chunk(input logic [ENTRY_W-1:0] ent,
                                                      input vec_t v,
                                                      input logic [CHUNK_MAX-1:0] c);
        logic [ENTRY_W-1:0] e;
        e = ent;
        for (int k = 0; k < CHUNK_MAX; k++) begin
            if (3'(k) <= v.len_m1)
                e[walk_index(v, k)] = c[v.len_m1 - 3'(k)];
        end
        return e;
    endfunction

    // take the next len bits of a word with rem bits left, MSB first
    function automatic logic [CHUNK_MAX-1:0] take_bits(input logic [ENTRY_W-1:0] word,
                                                       input logic [CNT_W-1:0] rem,
                                                       input logic [3:0] len);
        logic [ENTRY_W-1:0] t;
        logic [CNT_W-1:0]   l6;
        l6 = {2'b00, len};
        if (rem >= l6)
            t = word >> (rem - l6);
        else
            t = word << (l6 - rem);
        return t[CHUNK_MAX-1:0] & chunk_mask(len);
    endfunction

endpackage

// File: rtl/pack_cfg_decode.sv
module pack_cfg_decode
    import pack_pkg::*;
#(
    parameter int NUM_VEC = 4
) (
    input  logic [ENTRY_W-1:0]     cfg_lo,
    input  logic [ENTRY_W-1:0]     cfg_hi,
    output vec_t [NUM_VEC-1:0]     vecs
);
    localparam int PER_REG = NUM_VEC / 2;
    localparam int USED_W  = PER_REG * VEC_W;

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_lo[ENTRY_W-1:USED_W], cfg_hi[ENTRY_W-1:USED_W]};

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
        if (i < PER_REG) begin : g_lo
            assign vecs[i] = vec_t'(cfg_lo[(i % PER_REG)*VEC_W +: VEC_W]);
        end else begin : g_hi
            assign vecs[i] = vec_t'(cfg_hi[(i % PER_REG)*VEC_W +: VEC_W]);
        end
    end

endmodule

// File: rtl/pack_tx_unpack.sv
module pack_tx_unpack
    import pack_pkg::*;
#(
    parameter int NUM_VEC = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  vec_t [NUM_VEC-1:0]   vecs,
    input  logic [CNT_W-1:0]     width,
    input  logic                 ent_valid,
    output logic                 ent_ready,
    input  logic [ENTRY_W-1:0]   ent_data,
    output logic                 wrd_valid,
    input  logic                 wrd_ready,
    output logic [ENTRY_W-1:0]   wrd_data
);
    localparam int IDX_W = $clog2(NUM_VEC);

    logic                 busy;
    logic [ENTRY_W-1:0]   ent_q;
    logic [IDX_W-1:0]     vidx;
    logic [ENTRY_W-1:0]   acc;
    logic [CNT_W-1:0]     cnt;

    vec_t                 cur;
    logic [3:0]           len;
    logic [CHUNK_MAX-1:0] chunk;
    logic [ENTRY_W-1:0]   acc_n;
    logic [CNT_W-1:0]     cnt_n;
    logic                 last, emit, advance;

    always_comb begin
        cur     = vecs[vidx];
        len     = chunk_len(cur);
        chunk   = pull_chunk(ent_q, cur);
        acc_n   = (acc << len) | {{(ENTRY_W-CHUNK_MAX){1'b0}}, chunk};
        cnt_n   = cnt + {2'b00, len};
        last    = cur.stop || (vidx == IDX_W'(NUM_VEC-1));
        emit    = (cnt_n >= width) || last;
        advance = busy && (!wrd_valid || wrd_ready);
    end

    assign ent_ready = !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            ent_q     <= '0;
            vidx      <= '0;
            acc       <= '0;
            cnt       <= '0;
            wrd_valid <= 1'b0;
            wrd_data  <= '0;
        end else begin
            if (wrd_valid && wrd_ready)
                wrd_valid <= 1'b0;
            if (ent_valid && ent_ready) begin
                ent_q <= ent_data;
                busy  <= 1'b1;
                vidx  <= '0;
                acc   <= '0;
                cnt   <= '0;
            end
            if (advance) begin
                if (emit) begin
                    wrd_valid <= 1'b1;
                    wrd_data  <= acc_n & width_mask(width);
                    acc       <= '0;
                    cnt       <= '0;
                end else begin
                    acc <= acc_n;
                    cnt <= cnt_n;
                end
                if (last)
                    busy <= 1'b0;
                else
                    vidx <= vidx + IDX_W'(1);
            end
        end
    end

    assert_tx_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (wrd_valid && !wrd_ready) |=> (wrd_valid && $stable(wrd_data)));

    assert_tx_fits_R3: assert property (@(posedge clk) disable iff (rst)
        wrd_valid |-> ((wrd_data & ~width_mask(width)) == '0));

    assert_tx_one_entry_R5: assert property (@(posedge clk) disable iff (rst)
        (ent_valid && ent_ready) |=> !ent_ready);

endmodule

// File: rtl/pack_rx_pack.sv
module pack_rx_pack
    import pack_pkg::*;
#(
    parameter int NUM_VEC = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  vec_t [NUM_VEC-1:0]   vecs,
    input  logic [CNT_W-1:0]     width,
    input  logic                 wrd_valid,
    output logic                 wrd_ready,
    input  logic [ENTRY_W-1:0]   wrd_data,
    output logic                 ent_valid,
    input  logic                 ent_ready,
    output logic [ENTRY_W-1:0]   ent_data
);
    localparam int IDX_W = $clog2(NUM_VEC);

    logic [ENTRY_W-1:0]   word_q;
    logic [CNT_W-1:0]     rem;
    logic [ENTRY_W-1:0]   ent_acc;
    logic [IDX_W-1:0]     vidx;

    vec_t                 cur;
    logic [3:0]           len;
    logic [CHUNK_MAX-1:0] chunk;
    logic [ENTRY_W-1:0]   ent_n;
    logic [CNT_W-1:0]     rem_n;
    logic                 last, advance;

    always_comb begin
        cur     = vecs[vidx];
        len     = chunk_len(cur);
        chunk   = take_bits(word_q, rem, len);
        ent_n   = push_chunk(ent_acc, cur, chunk);
        rem_n   = (rem >= {2'b00, len}) ? (rem - {2'b00, len}) : '0;
        last    = cur.stop || (vidx == IDX_W'(NUM_VEC-1));
        advance = (rem != '0) && (!ent_valid || ent_ready);
    end

    assign wrd_ready = (rem == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q    <= '0;
            rem       <= '0;
            ent_acc   <= '0;
            vidx      <= '0;
            ent_valid <= 1'b0;
            ent_data  <= '0;
        end else begin
            if (ent_valid && ent_ready)
                ent_valid <= 1'b0;
            if (wrd_valid && wrd_ready) begin
                word_q <= wrd_data;
                rem    <= width;
            end
            if (advance) begin
                if (last) begin
                    ent_valid <= 1'b1;
                    ent_data  <= ent_n;
                    ent_acc   <= '0;
                    vidx      <= '0;
                    rem       <= '0;
                end else begin
                    ent_acc <= ent_n;
                    rem     <= rem_n;
                    vidx    <= vidx + IDX_W'(1);
                end
            end
        end
    end

    assert_rx_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (ent_valid && !ent_ready) |=> (ent_valid && $stable(ent_data)));

    assert_rx_load_R6: assert property (@(posedge clk) disable iff (rst)
        (wrd_valid && wrd_ready) |=> !wrd_ready);

    assert_rx_out_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ent_valid) |-> wrd_ready);

endmodule

// File: rtl/pack_word_unit.sv
module pack_word_unit
    import pack_pkg::*;
#(
    parameter int NUM_VEC = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] tx_cfg_lo,
    input  logic [31:0] tx_cfg_hi,
    input  logic [31:0] rx_cfg_lo,
    input  logic [31:0] rx_cfg_hi,
    input  logic [1:0]  gran_code,
    input  logic        tx_ent_valid,
    output logic        tx_ent_ready,
    input  logic [31:0] tx_ent_data,
    output logic        tx_wrd_valid,
    input  logic        tx_wrd_ready,
    output logic [31:0] tx_wrd_data,
    input  logic        rx_wrd_valid,
    output logic        rx_wrd_ready,
    input  logic [31:0] rx_wrd_data,
    output logic        rx_ent_valid,
    input  logic        rx_ent_ready,
    output logic [31:0] rx_ent_data
);
    vec_t [NUM_VEC-1:0] tx_vecs;
    vec_t [NUM_VEC-1:0] rx_vecs;
    logic [CNT_W-1:0]   width;

    assign width = gran_width(gran_code);

    pack_cfg_decode #(.NUM_VEC(NUM_VEC)) u_tx_cfg (
        .cfg_lo (tx_cfg_lo),
        .cfg_hi (tx_cfg_hi),
        .vecs   (tx_vecs)
    );

    pack_cfg_decode #(.NUM_VEC(NUM_VEC)) u_rx_cfg (
        .cfg_lo (rx_cfg_lo),
        .cfg_hi (rx_cfg_hi),
        .vecs   (rx_vecs)
    );

    pack_tx_unpack #(.NUM_VEC(NUM_VEC)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .vecs      (tx_vecs),
        .width     (width),
        .ent_valid (tx_ent_valid),
        .ent_ready (tx_ent_ready),
        .ent_data  (tx_ent_data),
        .wrd_valid (tx_wrd_valid),
        .wrd_ready (tx_wrd_ready),
        .wrd_data  (tx_wrd_data)
    );

    pack_rx_pack #(.NUM_VEC(NUM_VEC)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .vecs      (rx_vecs),
        .width     (width),
        .wrd_valid (rx_wrd_valid),
        .wrd_ready (rx_wrd_ready),
        .wrd_data  (rx_wrd_data),
        .ent_valid (rx_ent_valid),
        .ent_ready (rx_ent_ready),
        .ent_data  (rx_ent_data)
    );

    assert_reset_R10: assert property (@(posedge clk)
        $fell(rst) |-> (!tx_wrd_valid && !rx_ent_valid && tx_ent_ready && rx_wrd_ready));

endmodule

// File: tb/pack_word_unit_tb.sv
`timescale 1ns/1ps
module pack_word_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] tx_cfg_lo = '0, tx_cfg_hi = '0, rx_cfg_lo = '0, rx_cfg_hi = '0;
    logic [1:0]  gran_code = '0;
    logic        tx_ent_valid = 1'b0;
    logic        tx_ent_ready;
    logic [31:0] tx_ent_data = '0;
    logic        tx_wrd_valid;
    logic        tx_wrd_ready = 1'b0;
    logic [31:0] tx_wrd_data;
    logic        rx_wrd_valid = 1'b0;
    logic        rx_wrd_ready;
    logic [31:0] rx_wrd_data = '0;
    logic        rx_ent_valid;
    logic        rx_ent_ready = 1'b0;
    logic [31:0] rx_ent_data;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    pack_word_unit u_dut (
        .clk(clk), .rst(rst),
        .tx_cfg_lo(tx_cfg_lo), .tx_cfg_hi(tx_cfg_hi),
        .rx_cfg_lo(rx_cfg_lo), .rx_cfg_hi(rx_cfg_hi),
        .gran_code(gran_code),
        .tx_ent_valid(tx_ent_valid), .tx_ent_ready(tx_ent_ready), .tx_ent_data(tx_ent_data),
        .tx_wrd_valid(tx_wrd_valid), .tx_wrd_ready(tx_wrd_ready), .tx_wrd_data(tx_wrd_data),
        .rx_wrd_valid(rx_wrd_valid), .rx_wrd_ready(rx_wrd_ready), .rx_wrd_data(rx_wrd_data),
        .rx_ent_valid(rx_ent_valid), .rx_ent_ready(rx_ent_ready), .rx_ent_data(rx_ent_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] mkvec(input int s, input bit d, input int len, input bit stop);
        return {5'(s), d, 3'(len - 1), stop};
    endfunction

    function automatic logic [31:0] join2(input logic [9:0] a, input logic [9:0] b);
        return {12'd0, b, a};
    endfunction

    function automatic int wbits(input logic [1:0] g);
        return (g == 2'd1) ? 16 : (g == 2'd2) ? 32 : 8;
    endfunction

    function automatic logic [9:0] get_vec(input logic [31:0] lo, input logic [31:0] hi, input int v);
        logic [31:0] r;
        r = (v < 2) ? lo : hi;
        return r[(v % 2)*10 +: 10];
    endfunction

    // bit-serial transmit reference
    function automatic void tx_model(input logic [31:0] ent, input logic [31:0] lo, input logic [31:0] hi,
                                     input logic [1:0] g, output logic [31:0] w [4], output int n);
        logic [63:0] acc;
        logic [9:0]  vec;
        int cnt, wd, len, idx;
        acc = '0; cnt = 0; n = 0; wd = wbits(g);
        for (int j = 0; j < 4; j++) w[j] = '0;
        for (int v = 0; v < 4; v++) begin
            vec = get_vec(lo, hi, v);
            len = int'(vec[3:1]) + 1;
            for (int k = 0; k < len; k++) begin
                idx = vec[4] ? (int'(vec[9:5]) - k) & 31 : (int'(vec[9:5]) + k) & 31;
                acc = {acc[62:0], ent[idx]};
                cnt++;
            end
            if (cnt >= wd || vec[0] || v == 3) begin
                w[n] = (wd == 32) ? acc[31:0] : acc[31:0] & ((32'd1 << wd) - 32'd1);
                n++;
                acc = '0; cnt = 0;
            end
            if (vec[0]) break;
        end
    endfunction

    // bit-serial receive reference
    function automatic void rx_model(input logic [31:0] words [4], input logic [31:0] lo, input logic [31:0] hi,
                                     input logic [1:0] g, output logic [31:0] ent, output int n);
        logic [9:0]  vec;
        logic [31:0] word;
        logic        b;
        int rem, len, idx;
        ent = '0; n = 0; rem = 0; word = '0;
        for (int v = 0; v < 4; v++) begin
            vec = get_vec(lo, hi, v);
            if (rem == 0) begin
                word = words[n]; n++; rem = wbits(g);
            end
            len = int'(vec[3:1]) + 1;
            for (int k = 0; k < len; k++) begin
                if (rem > 0) begin b = word[rem-1]; rem--; end
                else b = 1'b0;
                idx = vec[4] ? (int'(vec[9:5]) - k) & 31 : (int'(vec[9:5]) + k) & 31;
                ent[idx] = b;
            end
            if (vec[0]) break;
        end
    endfunction

    task automatic drive_tx(input logic [31:0] ent);
        @(negedge clk);
        tx_ent_valid = 1'b1;
        tx_ent_data  = ent;
        while (!tx_ent_ready) @(negedge clk);
        @(posedge clk);
        #1 tx_ent_valid = 1'b0;
    endtask

    task automatic collect_tx(input int n, output logic [31:0] got [4]);
        int k;
        bit pend;
        logic [31:0] pd;
        k = 0; pend = 0; pd = '0;
        for (int j = 0; j < 4; j++) got[j] = '0;
        while (k < n) begin
            @(negedge clk);
            if (pend) begin
                chk(tx_wrd_valid && tx_wrd_data == pd, "R9 tx hold", tx_wrd_data, pd);
                pend = 0;
            end
            tx_wrd_ready = ($urandom % 4) != 0;
            if (tx_wrd_valid) begin
                if (tx_wrd_ready) begin got[k] = tx_wrd_data; k++; end
                else begin pend = 1; pd = tx_wrd_data; end
            end
        end
        @(posedge clk);
        #1 tx_wrd_ready = 1'b0;
    endtask

    task automatic run_tx(input logic [31:0] ent, input logic [31:0] lo, input logic [31:0] hi,
                          input logic [1:0] g, input string tag);
        logic [31:0] exp [4];
        logic [31:0] got [4];
        int n;
        tx_cfg_lo = lo; tx_cfg_hi = hi; gran_code = g;
        tx_model(ent, lo, hi, g, exp, n);
        fork
            drive_tx(ent);
            collect_tx(n, got);
        join
        for (int j = 0; j < n; j++)
            chk(got[j] == exp[j], tag, got[j], exp[j]);
        repeat (3) @(negedge clk);
        chk(!tx_wrd_valid && tx_ent_ready, {tag, " R5 no extra word"}, {31'd0, tx_wrd_valid}, 32'd0);
    endtask

    task automatic drive_rx(input logic [31:0] words [4], input int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            rx_wrd_valid = 1'b1;
            rx_wrd_data  = words[j];
            while (!rx_wrd_ready) @(negedge clk);
            @(posedge clk);
            #1 rx_wrd_valid = 1'b0;
        end
    endtask

    task automatic collect_rx(output logic [31:0] got);
        bit done, pend;
        logic [31:0] pd;
        done = 0; pend = 0; pd = '0; got = '0;
        while (!done) begin
            @(negedge clk);
            if (pend) begin
                chk(rx_ent_valid && rx_ent_data == pd, "R9 rx hold", rx_ent_data, pd);
                pend = 0;
            end
            rx_ent_ready = ($urandom % 4) != 0;
            if (rx_ent_valid) begin
                if (rx_ent_ready) begin got = rx_ent_data; done = 1; end
                else begin pend = 1; pd = rx_ent_data; end
            end
        end
        @(posedge clk);
        #1 rx_ent_ready = 1'b0;
    endtask

    task automatic run_rx(input logic [31:0] words [4], input logic [31:0] lo, input logic [31:0] hi,
                          input logic [1:0] g, input string tag);
        logic [31:0] exp, got;
        int n;
        rx_cfg_lo = lo; rx_cfg_hi = hi; gran_code = g;
        rx_model(words, lo, hi, g, exp, n);
        fork
            drive_rx(words, n);
            collect_rx(got);
        join
        chk(got == exp, tag, got, exp);
        @(negedge clk);
        chk(rx_wrd_ready && !rx_ent_valid, {tag, " R7 fresh word"}, {31'd0, rx_wrd_ready}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] lo8, hi8, lo16, hi16, lo32, hi32, w [4];
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!tx_wrd_valid && !rx_ent_valid, "R10 valids low", {30'd0, tx_wrd_valid, rx_ent_valid}, 32'd0);
        chk(tx_ent_ready && rx_wrd_ready, "R10 readies high", {30'd0, tx_ent_ready, rx_wrd_ready}, 32'd3);

        lo8  = join2(mkvec(7, 1, 8, 0),  mkvec(15, 1, 8, 0));
        hi8  = join2(mkvec(23, 1, 8, 0), mkvec(31, 1, 8, 1));
        lo16 = join2(mkvec(15, 1, 8, 0), mkvec(7, 1, 8, 0));
        hi16 = join2(mkvec(31, 1, 8, 0), mkvec(23, 1, 8, 1));
        lo32 = join2(mkvec(31, 1, 8, 0), mkvec(23, 1, 8, 0));
        hi32 = join2(mkvec(15, 1, 8, 0), mkvec(7, 1, 8, 1));

        run_tx(32'hA1B2C3D4, lo8, hi8, 2'd0, "R1 R2 byte lanes");
        run_tx(32'hA1B2C3D4, lo16, hi16, 2'd1, "R3 16-bit words");
        run_tx(32'hA1B2C3D4, lo32, hi32, 2'd2, "R4 32-bit word");
        run_tx(32'hA1B2C3D4, lo8, hi8, 2'd3, "R4 code 3 as 8-bit");
        run_tx(32'hA1B2C3D4, join2(mkvec(7, 1, 8, 1), 10'h155), 32'hFFFFF, 2'd0, "R5 early stop");
        run_tx(32'hA1B2C3D4, join2(mkvec(0, 0, 8, 1), 10'h0), 32'h0, 2'd0, "R2 ascending");
        run_tx(32'hA1B2C3D4, join2(mkvec(3, 1, 8, 1), 10'h0), 32'h0, 2'd0, "R2 wrap");

        w[0] = 32'hD4; w[1] = 32'hC3; w[2] = 32'hB2; w[3] = 32'hA1;
        run_rx(w, lo8, hi8, 2'd0, "R6 byte lanes");
        w[0] = 32'hABCD; w[1] = 32'h1234; w[2] = '0; w[3] = '0;
        run_rx(w, join2(mkvec(15, 1, 8, 1), 10'h0), 32'h0, 2'd1, "R7 discard rest");
        w[0] = 32'h1234;
        run_rx(w, join2(mkvec(15, 1, 8, 1), 10'h0), 32'h0, 2'd1, "R7 next entry");

        // R8: receive config left in place while transmit config changes
        rx_cfg_lo = lo8; rx_cfg_hi = hi8;
        run_tx(32'h0F1E2D3C, join2(mkvec(4, 0, 3, 1), 10'h3FF), 32'h0, 2'd0, "R8 tx own config");
        w[0] = 32'h11; w[1] = 32'h22; w[2] = 32'h33; w[3] = 32'h44;
        run_rx(w, lo8, hi8, 2'd0, "R8 rx unaffected");

        for (int it = 0; it < 150; it++) begin
            logic [31:0] rw [4];
            logic [1:0] g;
            g = 2'($urandom % 4);
            for (int j = 0; j < 4; j++) rw[j] = $urandom;
            run_tx($urandom, $urandom, $urandom, g, "R2 R3 R5 random tx");
            run_rx(rw, $urandom, $urandom, g, "R6 R7 random rx");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule